// File: doc/BRIEF.md
# Free-Running Tick Counter with Elapsed-Time Read

The block is a wide system counter that starts at zero out of reset and advances by one on every clock. A client reads it through one strobe with a two-bit mode. The absolute read returns the raw count. The elapsed read returns the number of ticks since the previous elapsed read, and the sampled count then becomes the reference for the next one. Time between two points in a program is measured with two elapsed reads, and no subtraction is done in software.

A narrow client can use two half-width reads. The low-half read returns the lower half of the count. In the same cycle it captures the upper half of that same sample. The high-half read then returns that captured value, so the two halves always belong to one count even when a carry crosses between them. Every read answers one clock after its strobe, together with a valid pulse. At the default 64-bit width the count wraps only after thousands of years at a few hundred MHz. Even so, all elapsed arithmetic is modulo 2^CNT_W, so a wrap never gives a wrong delta.

Top module: `tick_delta_timer`

## Requirements
- R1: While rst_ni is low and on the first cycle after it rises, rd_valid_o is 0 and rd_data_o is 0. Reset clears the count, the elapsed reference and the captured upper half.
- R2: The count advances by exactly one on every clock after reset. An absolute read (rd_mode_i = 2'b00) returns the count as it stands in the cycle where the strobe is sampled.
- R3: An elapsed read (rd_mode_i = 2'b01) returns the sampled count minus the stored reference, and stores that sampled count as the new reference. Two elapsed reads in consecutive cycles give 1 for the second read.
- R4: The first elapsed read after reset returns the number of ticks since reset, because the reference is reset to 0.
- R5: Absolute, low-half and high-half reads leave the elapsed reference unchanged.
- R6: rd_valid_o is high for exactly the cycle after each cycle with rd_req_i high, and low otherwise. rd_data_o holds its value in cycles with no read result.
- R7: A low-half read (rd_mode_i = 2'b10) returns bits [CNT_W/2-1:0] of the sampled count in the low half of rd_data_o, with the upper half zero. It captures bits [CNT_W-1:CNT_W/2] of the same sample.
- R8: A high-half read (rd_mode_i = 2'b11) returns the captured upper half in the low half of rd_data_o, with the upper half zero. Only a low-half read changes the captured value.
- R9: The count wraps from all ones to zero. An elapsed read across the wrap returns the true tick count, modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; the count advances on each rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_req_i | input | 1 | Read strobe, sampled on the rising edge |
| rd_mode_i | input | 2 | 00 absolute, 01 elapsed, 10 low half, 11 high half |
| rd_data_o | output | CNT_W (64) | Read result, registered |
| rd_valid_o | output | 1 | High one cycle after a strobe |

## Verification
The assertions check on every cycle that:
- the count steps by one;
- the valid pulse follows the strobe;
- the output and the elapsed reference hold when nothing allowed them to change;
- the captured upper half moves only on a low-half read;
- half-width results have a zero upper half.

The bench scenarios cover the rest:
- the values an elapsed read actually returns, including the first read after reset and back-to-back reads;
- the coherence of a split read;
- correct deltas across a wrap, using a second, 8-bit instance that wraps within the run.

// File: rtl/tick_pkg.sv
package tick_pkg;
  typedef enum logic [1:0] {
    RD_ABS   = 2'b00,
    RD_DELTA = 2'b01,
    RD_LOW   = 2'b10,
    RD_HIGH  = 2'b11
  } rd_mode_e;
endpackage

// File: rtl/tick_count.sv
module tick_count #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  // R2, R9: unit step, wrapping modulo 2^CNT_W
  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/tick_delta.sv
module tick_delta #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [CNT_W-1:0] sample_i,
  output logic [CNT_W-1:0] delta_o
);
  logic [CNT_W-1:0] ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ref_q <= '0;
    else if (take_i) ref_q <= sample_i;
  end

  // modulo subtraction covers wrap
  assign delta_o = sample_i - ref_q;

  p_ref_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(ref_q));
endmodule

// File: rtl/tick_split.sv
module tick_split #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             latch_i,
  input  logic [CNT_W-1:0] sample_i,
  output logic [CNT_W-1:0] lo_o,
  output logic [CNT_W-1:0] hi_o
);
  localparam int unsigned HALF_W = CNT_W / 2;

  logic [HALF_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_q <= '0;
    else if (latch_i) hi_q <= sample_i[CNT_W-1:HALF_W];
  end

  assign lo_o = {{(CNT_W-HALF_W){1'b0}}, sample_i[HALF_W-1:0]};
  assign hi_o = {{(CNT_W-HALF_W){1'b0}}, hi_q};

  p_hi_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> $stable(hi_q));
endmodule

// File: rtl/tick_delta_timer.sv
module tick_delta_timer
  import tick_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_req_i,
  input  logic [1:0]       rd_mode_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             rd_valid_o
);
  localparam int unsigned HALF_W = CNT_W / 2;

  rd_mode_e         mode;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] delta;
  logic [CNT_W-1:0] lo_word;
  logic [CNT_W-1:0] hi_word;
  logic [CNT_W-1:0] result;
  logic [CNT_W-1:0] data_q;
  logic             valid_q;

  assign mode = rd_mode_e'(rd_mode_i);

  tick_count #(.CNT_W(CNT_W)) u_count (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt)
  );

  tick_delta #(.CNT_W(CNT_W)) u_delta (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (rd_req_i && mode == RD_DELTA),
    .sample_i(cnt),
    .delta_o (delta)
  );

  tick_split #(.CNT_W(CNT_W)) u_split (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .latch_i (rd_req_i && mode == RD_LOW),
    .sample_i(cnt),
    .lo_o    (lo_word),
    .hi_o    (hi_word)
  );

  always_comb begin
    unique case (mode)
      RD_ABS:   result = cnt;
      RD_DELTA: result = delta;
      RD_LOW:   result = lo_word;
      RD_HIGH:  result = hi_word;
      default:  result = cnt;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_req_i;
      if (rd_req_i) data_q <= result;
    end
  end

  assign rd_data_o  = data_q;
  assign rd_valid_o = valid_q;

  p_valid_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rd_valid_o);
  p_valid_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> !rd_valid_o);
  p_data_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> $stable(rd_data_o));
  p_half_zext_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && rd_mode_i[1]) |=> rd_data_o[CNT_W-1:HALF_W] == '0);
endmodule

// File: tb/tick_delta_timer_bench.sv
module tick_delta_timer_bench;
  localparam int unsigned NW = 8;
  localparam int NVEC = 16;
  // {narrow, mode, gap}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b0, 2'b01, 8'd3},  {1'b0, 2'b00, 8'd5},  {1'b0, 2'b01, 8'd7},
    {1'b0, 2'b10, 8'd2},  {1'b0, 2'b11, 8'd9},  {1'b0, 2'b01, 8'd1},
    {1'b0, 2'b00, 8'd0},  {1'b0, 2'b11, 8'd4},  {1'b1, 2'b01, 8'd2},
    {1'b1, 2'b10, 8'd6},  {1'b1, 2'b11, 8'd30}, {1'b1, 2'b00, 8'd3},
    {1'b1, 2'b01, 8'd11}, {1'b0, 2'b01, 8'd0},  {1'b1, 2'b10, 8'd17},
    {1'b1, 2'b11, 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_w = 1'b0, req_n = 1'b0;
  logic [1:0] mode_w = 2'b00, mode_n = 2'b00;
  logic [63:0] data_w;
  logic [NW-1:0] data_n;
  logic valid_w, valid_n;

  int checks = 0;
  int errors = 0;
  logic [63:0] ticks;
  logic [63:0] ref_m [2];
  logic [63:0] hi_m [2];

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ticks <= '0;
    else        ticks <= ticks + 64'd1;

  tick_delta_timer u_tick_delta_timer (
    .clk_i(clk), .rst_ni(rst_n), .rd_req_i(req_w), .rd_mode_i(mode_w),
    .rd_data_o(data_w), .rd_valid_o(valid_w)
  );

  tick_delta_timer #(.CNT_W(NW)) u_tick_delta_timer_narrow (
    .clk_i(clk), .rst_ni(rst_n), .rd_req_i(req_n), .rd_mode_i(mode_n),
    .rd_data_o(data_n), .rd_valid_o(valid_n)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] wmask(input bit n);
    return n ? 64'hFF : 64'hFFFF_FFFF_FFFF_FFFF;
  endfunction

  function automatic logic [63:0] hmask(input bit n);
    return n ? 64'hF : 64'hFFFF_FFFF;
  endfunction

  function automatic int hshift(input bit n);
    return n ? 4 : 32;
  endfunction

  // drive at negedge, result checked at the following negedge
  task automatic do_read(input bit n, input logic [1:0] m, input string tag);
    logic [63:0] s, exp;
    s = ticks & wmask(n);
    unique case (m)
      2'b00: exp = s;
      2'b01: begin exp = (s - ref_m[n]) & wmask(n); ref_m[n] = s; end
      2'b10: begin exp = s & hmask(n); hi_m[n] = s >> hshift(n); end
      default: exp = hi_m[n];
    endcase
    if (n) begin req_n = 1'b1; mode_n = m; end
    else   begin req_w = 1'b1; mode_w = m; end
    @(negedge clk);
    req_w = 1'b0; req_n = 1'b0;
    if (n) begin
      chk({63'd0, valid_n}, 64'd1, {tag, " valid R6"});
      chk({56'd0, data_n}, exp, tag);
    end else begin
      chk({63'd0, valid_w}, 64'd1, {tag, " valid R6"});
      chk(data_w, exp, tag);
    end
  endtask

  task automatic reset_models();
    for (int i = 0; i < 2; i++) begin ref_m[i] = '0; hi_m[i] = '0; end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] held;
    reset_models();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({63'd0, valid_w}, 64'd0, "R1 valid in reset");
    chk(data_w, 64'd0, "R1 data in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk({63'd0, valid_w}, 64'd0, "R1 valid after reset");
    chk(data_w, 64'd0, "R1 data after reset");
    // R4: first elapsed read reports ticks since reset
    repeat (4) @(negedge clk);
    do_read(1'b0, 2'b01, "R4 first delta");
    // R2: absolute, then R5: reference untouched by absolute and split reads
    do_read(1'b0, 2'b00, "R2 absolute");
    do_read(1'b0, 2'b10, "R7 low half");
    do_read(1'b0, 2'b11, "R8 high half");
    do_read(1'b0, 2'b01, "R5 delta after other reads");
    // R6: idle cycles keep valid low and data stable
    held = data_w;
    repeat (3) @(negedge clk);
    chk({63'd0, valid_w}, 64'd0, "R6 idle valid");
    chk(data_w, held, "R6 idle data hold");

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      repeat (int'(VEC[v][7:0])) @(negedge clk);
      do_read(VEC[v][10], VEC[v][9:8], $sformatf("R3 vector %0d", v));
    end

    // R3: back-to-back elapsed reads; second returns 1
    req_w = 1'b1; mode_w = 2'b01;
    ref_m[0] = ticks;
    @(negedge clk);
    @(negedge clk);
    req_w = 1'b0;
    chk(data_w, 64'd1, "R3 back-to-back delta");
    @(negedge clk);
    chk({63'd0, valid_w}, 64'd0, "R6 valid drops");

    // R9: elapsed across wrap of the 8-bit instance
    while ((ticks & 64'hFF) != 64'd250) @(negedge clk);
    do_read(1'b1, 2'b01, "R9 delta before wrap");
    repeat (19) @(negedge clk);
    do_read(1'b1, 2'b01, "R9 delta across wrap");
    chk({56'd0, data_n}, 64'd20, "R9 delta across wrap literal");
    do_read(1'b1, 2'b00, "R9 wrapped absolute");

    // R7/R8: split read across a low-half carry on the narrow instance
    while ((ticks & 64'hF) != 64'd15) @(negedge clk);
    do_read(1'b1, 2'b10, "R7 low at carry edge");
    repeat (2) @(negedge clk);
    do_read(1'b1, 2'b11, "R8 coherent high");

    // R4 again after a mid-run reset
    rst_n = 1'b0;
    reset_models();
    @(negedge clk);
    chk(data_w, 64'd0, "R1 data after mid reset");
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    do_read(1'b0, 2'b01, "R4 delta after mid reset");
    do_read(1'b0, 2'b11, "R1 high latch cleared");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule